// File: doc/BRIEF.md
# Quick Add/Subtract Execute Unit

This block is the execute stage for the quick add and quick subtract instructions of a CPU with a 32-bit register file. The file holds eight data registers and eight address registers. For each operation the block receives the current value of the destination register, the condition flags, a 3-bit immediate field, a size code and a direction (add or subtract). One clock later it returns the value to write back, a write enable, the new flags and a flag-update enable.

The destination class changes the behaviour. A data-register destination is changed only at the operation size, and its flags are computed at that size. An address-register destination is always updated across all 32 bits and its flags never move. A byte operation into an address register is rejected, and so is the reserved size code. A rejected operation raises an illegal indication and causes no write-back.

Control is a three-state machine. `ST_IDLE` means no result is presented. `ST_WRITE` presents a legal result. `ST_TRAP` presents a rejected operation. From any state, a strobe with a legal combination moves to `ST_WRITE`. From any state, a strobe with an illegal combination moves to `ST_TRAP`. From any state, a cycle with no strobe returns to `ST_IDLE`. Synchronous reset forces `ST_IDLE`.

Top module: `qarith_exec`

## Requirements
- R1: The immediate field value 000 stands for the operand 8. Every other field value stands for itself, so the operand is always between 1 and 8.
- R2: For a data destination, `in_sub`=0 adds the operand and `in_sub`=1 subtracts it. Size code 00 (byte) replaces only bits 7:0 of the register, size code 01 (word) replaces only bits 15:0, and size code 10 (long) replaces all 32 bits. Bits above the operation size keep their value from `src_val`.
- R3: For an address destination with a word or long size, `wb_val` is the full 32-bit sum or difference of `src_val` and the operand. The word and long sizes give identical results.
- R4: A byte-size operation (size code 00) into an address destination produces `illegal`=1, `wb_en`=0 and `flags_en`=0. In that case `flags_out` equals the `flags_in` that was presented with it.
- R5: For an address destination, `flags_en`=0 and `flags_out` equals the `flags_in` that was presented with the operation.
- R6: For a data destination, the negative flag (`flags_out` bit 3) is the most significant bit of the result at the operation size. The zero flag (bit 2) is 1 exactly when the result at that size is zero.
- R7: For a data destination, the carry flag (bit 0) is the carry out of the most significant bit at the operation size for an add, or the borrow for a subtract. The extend flag (bit 4) equals the carry flag.
- R8: For a data destination, the overflow flag (bit 1) is signed overflow at the operation size.
- R9: Outputs are registered. `out_valid` is 1 in the cycle after an `in_valid` cycle and 0 after a cycle without one. `wb_idx` and `wb_addr` echo the destination of that operation.
- R10: Synchronous reset clears `out_valid` and `flags_out`, even when `in_valid` is high at the same time.
- R11: The reserved size code 11 is illegal for either destination class. It gives `illegal`=1 and `wb_en`=0, and `flags_out` equals the `flags_in` that was presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| imm | input | 3 | Immediate field (000 means 8) |
| size | input | 2 | 00 byte, 01 word, 10 long, 11 reserved |
| dst_addr | input | 1 | 1 = address register, 0 = data register |
| dst_idx | input | 3 | Destination register index |
| src_val | input | 32 | Current destination register value |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| out_valid | output | 1 | Result presented this cycle |
| wb_en | output | 1 | Write-back enable |
| wb_val | output | 32 | Value to write back |
| wb_idx | output | 3 | Destination index of the result |
| wb_addr | output | 1 | Destination class of the result |
| flags_out | output | 5 | Flag register {X,N,Z,V,C} |
| flags_en | output | 1 | Flag update enable |
| illegal | output | 1 | Rejected operation |

## Verification
Every internal fault shows at the ports in the very next cycle, because one register stage separates each input from its output. A wrong state shows up in one of three ways. `wb_en` may be asserted together with `illegal`. `out_valid` may stay high after a cycle with no strobe. `flags_en` may be raised for an address destination. A fault in the lane arithmetic or the merge appears as wrong low bits, wrong upper bits or wrong flags. The sweep covers every combination of direction, size, class and immediate value against sources placed at the sign and carry boundaries of each size, so such a fault surfaces within the first few vectors that cross the boundary concerned.

// File: rtl/qarith_pkg.sv
`timescale 1ns/1ps
package qarith_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_TRAP
    } state_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam int CCR_W = 5;
endpackage

// File: rtl/qarith_operand.sv
`timescale 1ns/1ps
module qarith_operand #(
    parameter int IMM_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] operand
);
    localparam logic [DATA_W-1:0] WRAP_VAL = DATA_W'(1) << IMM_W;

    always_comb begin
        if (imm == '0) begin
            operand = WRAP_VAL;
        end else begin
            operand = DATA_W'(imm);
        end
    end
endmodule

// File: rtl/qarith_lane.sv
`timescale 1ns/1ps
module qarith_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);
    logic [W:0] ext;

    always_comb begin
        if (sub) begin
            ext = {1'b0, a} - {1'b0, b};
            ovf = (a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]);
        end else begin
            ext = {1'b0, a} + {1'b0, b};
            ovf = (a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]);
        end
        res   = ext[W-1:0];
        carry = ext[W];
    end
endmodule

// File: rtl/qarith_alu.sv
`timescale 1ns/1ps
module qarith_alu
    import qarith_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] res_sz,
    output logic [DATA_W-1:0] res_full,
    output ccr_t              ccr
);
    localparam int NLANE = 3;

    logic [DATA_W-1:0] lane_res [NLANE];
    logic [NLANE-1:0]  lane_c;
    logic [NLANE-1:0]  lane_v;
    logic [NLANE-1:0]  lane_n;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = DATA_W >> (NLANE - 1 - g);
        logic [LW-1:0] r;
        qarith_lane #(.W(LW)) u_lane (
            .a     (a[LW-1:0]),
            .b     (b[LW-1:0]),
            .sub   (sub),
            .res   (r),
            .carry (lane_c[g]),
            .ovf   (lane_v[g])
        );
        assign lane_res[g] = DATA_W'(r);
        assign lane_n[g]   = r[LW-1];
    end

    logic [1:0] sel;

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: sel = 2'd0;
            SZ_WORD: sel = 2'd1;
            default: sel = 2'd2;
        endcase
        res_sz   = lane_res[sel];
        res_full = lane_res[NLANE-1];
        ccr.c    = lane_c[sel];
        ccr.x    = lane_c[sel];
        ccr.v    = lane_v[sel];
        ccr.n    = lane_n[sel];
        ccr.z    = (lane_res[sel] == '0);
    end
endmodule

// File: rtl/qarith_merge.sv
`timescale 1ns/1ps
module qarith_merge
    import qarith_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] res_sz,
    input  logic [DATA_W-1:0] res_full,
    input  logic [1:0]        size,
    input  logic              dst_addr,
    output logic [DATA_W-1:0] wb
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    always_comb begin
        if (dst_addr) begin
            wb = res_full;
        end else begin
            unique case (size_e'(size))
                SZ_BYTE: wb = {src[DATA_W-1:BYTE_W], res_sz[BYTE_W-1:0]};
                SZ_WORD: wb = {src[DATA_W-1:WORD_W], res_sz[WORD_W-1:0]};
                default: wb = res_sz;
            endcase
        end
    end
endmodule

// File: rtl/qarith_exec.sv
`timescale 1ns/1ps
module qarith_exec
    import qarith_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sub,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        size,
    input  logic              dst_addr,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [DATA_W-1:0] src_val,
    input  logic [4:0]        flags_in,
    output logic              out_valid,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_val,
    output logic [IDX_W-1:0]  wb_idx,
    output logic              wb_addr,
    output logic [4:0]        flags_out,
    output logic              flags_en,
    output logic              illegal
);
    state_e            state_q, state_d;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] res_sz, res_full, wb_d;
    ccr_t              ccr_new;
    ccr_t              ccr_q;
    logic [DATA_W-1:0] wb_q;
    logic [IDX_W-1:0]  idx_q;
    logic              addr_q;
    logic              legal;

    qarith_operand #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_operand (
        .imm     (imm),
        .operand (operand)
    );

    qarith_alu #(.DATA_W(DATA_W)) u_alu (
        .a        (src_val),
        .b        (operand),
        .sub      (in_sub),
        .size     (size),
        .res_sz   (res_sz),
        .res_full (res_full),
        .ccr      (ccr_new)
    );

    qarith_merge #(.DATA_W(DATA_W)) u_merge (
        .src      (src_val),
        .res_sz   (res_sz),
        .res_full (res_full),
        .size     (size),
        .dst_addr (dst_addr),
        .wb       (wb_d)
    );

    assign legal = (size_e'(size) != SZ_RSVD) &&
                   !(dst_addr && (size_e'(size) == SZ_BYTE));

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = legal ? ST_WRITE : ST_TRAP;
            end
            ST_WRITE: begin
                if (in_valid) state_d = legal ? ST_WRITE : ST_TRAP;
            end
            ST_TRAP: begin
                if (in_valid) state_d = legal ? ST_WRITE : ST_TRAP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q  <= '0;
            wb_q   <= '0;
            idx_q  <= '0;
            addr_q <= 1'b0;
        end else if (in_valid) begin
            wb_q   <= wb_d;
            idx_q  <= dst_idx;
            addr_q <= dst_addr;
            if (legal && !dst_addr) begin
                ccr_q <= ccr_new;
            end else begin
                ccr_q <= ccr_t'(flags_in);
            end
        end
    end

    always_comb begin
        out_valid = 1'b0;
        wb_en     = 1'b0;
        flags_en  = 1'b0;
        illegal   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WRITE: begin
                out_valid = 1'b1;
                wb_en     = 1'b1;
                flags_en  = !addr_q;
            end
            ST_TRAP: begin
                out_valid = 1'b1;
                illegal   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign wb_val    = wb_q;
    assign wb_idx    = idx_q;
    assign wb_addr   = addr_q;
    assign flags_out = ccr_q;
endmodule

// File: rtl/qarith_exec_chk.sv
`timescale 1ns/1ps
module qarith_exec_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 3,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sub,
    input logic [IMM_W-1:0]  imm,
    input logic [1:0]        size,
    input logic              dst_addr,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [DATA_W-1:0] src_val,
    input logic [4:0]        flags_in,
    input logic              out_valid,
    input logic              wb_en,
    input logic [DATA_W-1:0] wb_val,
    input logic [IDX_W-1:0]  wb_idx,
    input logic              wb_addr,
    input logic [4:0]        flags_out,
    input logic              flags_en,
    input logic              illegal
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_byte_addr_trap_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_addr && size == 2'b00) |=> (illegal && !wb_en && !flags_en));

    assert_rsvd_trap_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'b11) |=> (illegal && !wb_en));

    assert_addr_flags_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_addr) |=> (!flags_en && flags_out == $past(flags_in)));

    assert_byte_upper_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dst_addr && size == 2'b00)
            |=> (wb_val[DATA_W-1:BYTE_W] == $past(src_val[DATA_W-1:BYTE_W])));

    assert_word_upper_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dst_addr && size == 2'b01)
            |=> (wb_val[DATA_W-1:WORD_W] == $past(src_val[DATA_W-1:WORD_W])));

    assert_extend_eq_carry_R7: assert property (@(posedge clk) disable iff (rst)
        flags_en |-> (flags_out[4] == flags_out[0]));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        flags_en |-> (flags_out[2] ==
            (($past(size) == 2'b00) ? (wb_val[BYTE_W-1:0] == '0) :
             ($past(size) == 2'b01) ? (wb_val[WORD_W-1:0] == '0) :
                                      (wb_val == '0))));

    assert_no_write_on_trap_R4: assert property (@(posedge clk) disable iff (rst)
        !(wb_en && illegal));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && flags_out == '0));
endmodule

bind qarith_exec qarith_exec_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .IDX_W  (IDX_W)
) u_chk (.*);

// File: tb/qarith_exec_test.sv
`timescale 1ns/1ps
module qarith_exec_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_sub;
    logic [2:0]  imm;
    logic [1:0]  size;
    logic        dst_addr;
    logic [2:0]  dst_idx;
    logic [31:0] src_val;
    logic [4:0]  flags_in;
    logic        out_valid, wb_en, wb_addr, flags_en, illegal;
    logic [31:0] wb_val;
    logic [2:0]  wb_idx;
    logic [4:0]  flags_out;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    qarith_exec uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sub(in_sub), .imm(imm),
        .size(size), .dst_addr(dst_addr), .dst_idx(dst_idx), .src_val(src_val),
        .flags_in(flags_in), .out_valid(out_valid), .wb_en(wb_en), .wb_val(wb_val),
        .wb_idx(wb_idx), .wb_addr(wb_addr), .flags_out(flags_out),
        .flags_en(flags_en), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int k);
        case (k)
            0:  return 32'h0000_0000;
            1:  return 32'h0000_0001;
            2:  return 32'h0000_0007;
            3:  return 32'h0000_007F;
            4:  return 32'h0000_0080;
            5:  return 32'h0000_00FF;
            6:  return 32'hA5A5_00F9;
            7:  return 32'h0000_7FFF;
            8:  return 32'h0000_8000;
            9:  return 32'h5A5A_FFFF;
            10: return 32'h7FFF_FFFF;
            11: return 32'h8000_0000;
            12: return 32'hFFFF_FFFF;
            13: return 32'h1234_5678;
            14: return 32'hC3C3_0004;
            default: return 32'h0001_0000;
        endcase
    endfunction

    task automatic run_one(input bit sub, input logic [2:0] im, input logic [1:0] sz,
                           input bit adr, input logic [2:0] idx,
                           input logic [31:0] src, input logic [4:0] fin);
        longint unsigned b, a, mask, full, r;
        int w;
        bit ill, c, v, n, z, am, bm, rm;
        logic [31:0] exp_wb;
        @(negedge clk);
        in_valid = 1'b1; in_sub = sub; imm = im; size = sz;
        dst_addr = adr; dst_idx = idx; src_val = src; flags_in = fin;
        @(negedge clk);
        in_valid = 1'b0;
        b   = (im == 3'd0) ? 64'd8 : 64'(im);
        ill = (sz == 2'b11) || (adr && sz == 2'b00);
        check("R9 out_valid", 32'(out_valid), 32'd1);
        check("R9 wb_idx", 32'(wb_idx), 32'(idx));
        check("R9 wb_addr", 32'(wb_addr), 32'(adr));
        if (ill) begin
            if (sz == 2'b11) begin
                check("R11 illegal", 32'(illegal), 32'd1);
                check("R11 wb_en", 32'(wb_en), 32'd0);
                check("R11 flags_out", 32'(flags_out), 32'(fin));
            end else begin
                check("R4 illegal", 32'(illegal), 32'd1);
                check("R4 wb_en", 32'(wb_en), 32'd0);
                check("R4 flags_en", 32'(flags_en), 32'd0);
                check("R4 flags_out", 32'(flags_out), 32'(fin));
            end
        end else if (adr) begin
            exp_wb = sub ? (src - 32'(b)) : (src + 32'(b));
            check("R3 wb_en", 32'(wb_en), 32'd1);
            check("R3 wb_val", wb_val, exp_wb);
            check("R5 flags_en", 32'(flags_en), 32'd0);
            check("R5 flags_out", 32'(flags_out), 32'(fin));
        end else begin
            w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
            mask = (64'd1 << w) - 64'd1;
            a    = 64'(src) & mask;
            full = sub ? (a - b) : (a + b);
            r    = full & mask;
            c    = sub ? (a < b) : ((full >> w) & 64'd1) != 0;
            n    = ((r >> (w - 1)) & 64'd1) != 0;
            z    = (r == 0);
            am   = ((a >> (w - 1)) & 64'd1) != 0;
            bm   = ((b >> (w - 1)) & 64'd1) != 0;
            rm   = n;
            v    = sub ? ((am != bm) && (rm != am)) : ((am == bm) && (rm != am));
            exp_wb = (src & ~32'(mask)) | 32'(r);
            check("R2 wb_en", 32'(wb_en), 32'd1);
            check("R2 illegal", 32'(illegal), 32'd0);
            check("R2 wb_val", wb_val, exp_wb);
            check("R6 flags_en", 32'(flags_en), 32'd1);
            check("R6 N", 32'(flags_out[3]), 32'(n));
            check("R6 Z", 32'(flags_out[2]), 32'(z));
            check("R7 C", 32'(flags_out[0]), 32'(c));
            check("R7 X", 32'(flags_out[4]), 32'(c));
            check("R8 V", 32'(flags_out[1]), 32'(v));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sub = 1'b0; imm = '0; size = '0;
        dst_addr = 1'b0; dst_idx = '0; src_val = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", 32'(out_valid), 32'd0);
        check("R10 reset flags_out", 32'(flags_out), 32'd0);
        rst = 1'b0;

        // R1: field 000 adds eight, field 001 adds one
        run_one(1'b0, 3'd0, 2'b10, 1'b0, 3'd1, 32'd0, 5'd0);
        check("R1 imm 000 is 8", wb_val, 32'd8);
        run_one(1'b0, 3'd1, 2'b10, 1'b0, 3'd1, 32'd0, 5'd0);
        check("R1 imm 001 is 1", wb_val, 32'd1);

        for (int op = 0; op < 2; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int ad = 0; ad < 2; ad++)
                    for (int im = 0; im < 8; im++)
                        for (int k = 0; k < 16; k++)
                            run_one(op[0], im[2:0], sz[1:0], ad[0], 3'(k + im),
                                    pattern(k), 5'(k * 7 + im));

        // R9: no strobe, no valid result
        @(negedge clk);
        check("R9 idle out_valid", 32'(out_valid), 32'd0);
        check("R9 idle wb_en", 32'(wb_en), 32'd0);

        // R10: reset beats a concurrent strobe and clears set flags
        run_one(1'b1, 3'd1, 2'b00, 1'b0, 3'd2, 32'd0, 5'd0);
        check("R10 flags set before reset", 32'(flags_out), 32'h19);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R10 reset out_valid", 32'(out_valid), 32'd0);
        check("R10 reset flags_out", 32'(flags_out), 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule